// File: doc/BRIEF.md
# Two-Probe Direct-Mapped Cache Lookup Controller

This block answers processor reads from a small direct-mapped array held in registers. The array is split into a lower and an upper half. Each address has a home slot in one half and a partner slot at the same position in the other half, so two lines that collide on the home slot can both stay resident. A request first probes its home slot. If that fails, it probes the partner slot in the following cycle. If both fail, it asks the next memory level for the word.

There are three outcomes. A home hit answers one cycle after the request is taken. A partner hit answers one cycle later and is a slow hit. A miss answers in the cycle the refill data comes back. Because the latency varies, the response carries a valid strobe and a two-bit outcome code rather than relying on a fixed delay. A slow hit swaps the two lines so that the line just used moves to the fast slot. A refill puts the new line in the home slot and moves the previous home line to the partner slot.

Top module: `pac_lookup`

## Requirements
- R1: After reset every slot is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first read of any address is therefore a miss.
- R2: When the tag in the home slot (index = address bits [IDX_W-1:0]) matches, `rsp_valid` is 1 in the cycle after acceptance, with `rsp_kind` = 2'b01 and the cached word on `rsp_data`.
- R3: The partner slot index is the home index with its top bit inverted. A match there, with the home slot failing, gives `rsp_valid` two cycles after acceptance, with `rsp_kind` = 2'b10.
- R4: A partner hit exchanges the home and partner lines. An immediate repeat of the same address is then a home hit, and the line that was displaced is now found by a partner hit.
- R5: Only when both slots fail does `mem_req_valid` rise, with `mem_req_addr` equal to the request address. Both stay steady until `mem_rsp_valid`, and no response is given before that. A miss answers 2 + N cycles after acceptance when memory replies N cycles after the request.
- R6: A miss responds with `rsp_kind` = 2'b11 and `rsp_data` = `mem_rsp_data`, in the cycle `mem_rsp_valid` is 1. The new line fills the home slot, the old home line moves to the partner slot, and the old partner line is dropped.
- R7: A stored tag is address bits [ADDR_W-1:IDX_W-1], so it includes the index top bit. Two addresses that differ only in that bit never match each other's line.
- R8: `req_ready` is 0 from acceptance until the response. Exactly one response with a non-zero `rsp_kind` is produced for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 01 home hit, 10 partner hit, 11 miss |
| rsp_data | output | DATA_W | Returned word |
| mem_req_valid | output | 1 | Refill request to next level |
| mem_req_addr | output | ADDR_W | Refill address |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
The hardest cases to reach from the ports are those where a line sits in its partner slot and is later evicted through a refill of a colliding address. Three distinct tags have to be walked through one slot pair in a fixed order. The stimulus sequence does exactly that: two tags collide on one home slot, then a third address whose index differs only in the top bit refills the pair. Each step's outcome code and latency expose the slot contents. A repeat of the evicted address must then miss. The refill delay is varied between runs of the same pattern.

// File: rtl/pac_pkg.sv
package pac_pkg;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 32;
    localparam int TAG_W  = ADDR_W - IDX_W + 1;
    localparam int SLOTS  = 1 << IDX_W;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_HIT    = 2'b01,
        KIND_PSEUDO = 2'b10,
        KIND_MISS   = 2'b11
    } kind_e;

    typedef enum logic [1:0] {OP_NONE, OP_SWAP, OP_REFILL} op_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    function automatic logic [IDX_W-1:0] home_idx(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [IDX_W-1:0] partner_idx(input logic [IDX_W-1:0] i);
        return i ^ (IDX_W'(1) << (IDX_W-1));
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W-1];
    endfunction
endpackage

// File: rtl/pac_array.sv
module pac_array
    import pac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] p_idx,
    input  logic [IDX_W-1:0] a_idx,
    input  op_e              op,
    input  line_t            fill_line,
    output line_t            p_line,
    output line_t            a_line
);
    line_t slots [SLOTS];

    assign p_line = slots[p_idx];
    assign a_line = slots[a_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
        end else begin
            case (op)
                OP_SWAP: begin
                    slots[p_idx] <= slots[a_idx];
                    slots[a_idx] <= slots[p_idx];
                end
                OP_REFILL: begin
                    slots[p_idx] <= fill_line;
                    slots[a_idx] <= slots[p_idx];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pac_match.sv
module pac_match
    import pac_pkg::*;
(
    input  line_t            line,
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    assign hit = line.valid && (line.tag == tag);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
    import pac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              hit_p,
    input  logic              hit_a,
    input  logic              mem_rsp_valid,
    output logic              req_ready,
    output logic [ADDR_W-1:0] cur_addr,
    output op_e               op,
    output kind_e             kind,
    output logic              mem_req_valid
);
    typedef enum logic [1:0] {ST_IDLE, ST_HOME, ST_PARTNER, ST_FILL} st_e;
    st_e st, st_nx;

    always_comb begin
        st_nx         = st;
        op            = OP_NONE;
        kind          = KIND_NONE;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        case (st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) st_nx = ST_HOME;
            end
            ST_HOME: begin
                if (hit_p) begin
                    kind  = KIND_HIT;
                    st_nx = ST_IDLE;
                end else begin
                    st_nx = ST_PARTNER;
                end
            end
            ST_PARTNER: begin
                if (hit_a) begin
                    kind  = KIND_PSEUDO;
                    op    = OP_SWAP;
                    st_nx = ST_IDLE;
                end else begin
                    st_nx = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_rsp_valid) begin
                    kind  = KIND_MISS;
                    op    = OP_REFILL;
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_addr <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && req_valid) cur_addr <= req_addr;
        end
    end
endmodule

// File: rtl/pac_lookup.sv
module pac_lookup
    import pac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  p_idx, a_idx;
    logic [TAG_W-1:0]  cur_tag;
    line_t             p_line, a_line, fill_line;
    logic              hit_p, hit_a;
    op_e               op;
    kind_e             kind;

    assign p_idx     = home_idx(cur_addr);
    assign a_idx     = partner_idx(p_idx);
    assign cur_tag   = tag_of(cur_addr);
    assign fill_line = '{valid: 1'b1, tag: cur_tag, data: mem_rsp_data};

    pac_ctrl u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .hit_p(hit_p), .hit_a(hit_a), .mem_rsp_valid(mem_rsp_valid),
        .req_ready(req_ready), .cur_addr(cur_addr), .op(op), .kind(kind),
        .mem_req_valid(mem_req_valid)
    );

    pac_array u_array (
        .clk(clk), .rst(rst), .p_idx(p_idx), .a_idx(a_idx), .op(op),
        .fill_line(fill_line), .p_line(p_line), .a_line(a_line)
    );

    pac_match u_match_p (.line(p_line), .tag(cur_tag), .hit(hit_p));
    pac_match u_match_a (.line(a_line), .tag(cur_tag), .hit(hit_a));

    assign rsp_valid    = (kind != KIND_NONE);
    assign rsp_kind     = kind;
    assign mem_req_addr = cur_addr;

    always_comb begin
        case (kind)
            KIND_HIT:    rsp_data = p_line.data;
            KIND_PSEUDO: rsp_data = a_line.data;
            KIND_MISS:   rsp_data = mem_rsp_data;
            default:     rsp_data = '0;
        endcase
    end
endmodule

// File: rtl/pac_lookup_chk.sv
module pac_lookup_chk
    import pac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid));

    assert_fast_hit_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'b01) |-> $past(req_valid && req_ready));

    assert_slow_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'b10) |-> $past(req_valid && req_ready, 2));

    assert_refill_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_miss_with_data_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'b11) |-> (mem_req_valid && mem_rsp_valid));

    assert_busy_while_answering_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!req_ready && rsp_kind != 2'b00));
endmodule

bind pac_lookup pac_lookup_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/sim_pac_lookup.sv
module sim_pac_lookup;
    import pac_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic              clk = 0, rst = 1;
    logic              req_valid = 0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [DATA_W-1:0] rsp_data;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        kind;
        int                lat;
        string             req;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0, cyc = 0, accept_cyc = 0, mem_lat = 1, wait_cnt = 0;
    logic [ADDR_W-1:0] exp_mem_addr = '0;

    pac_lookup u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return {a, 8'h5A, ~a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // driver: pushes the expected outcome, then hands the request over
    task automatic send(input logic [ADDR_W-1:0] a, input logic [1:0] k, input string req);
        exp_t e;
        e.addr = a; e.kind = k; e.req = req;
        e.lat  = (k == 2'b01) ? 1 : (k == 2'b10) ? 2 : 2 + mem_lat;
        q.push_back(e);
        exp_mem_addr = a;
        @(negedge clk);
        req_valid = 1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        accept_cyc = cyc;
        @(negedge clk);
        req_valid = 0;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    // monitor: pops and compares each response
    initial forever begin
        @(negedge clk);
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                check(0, "R8", "unexpected response", rsp_kind, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_kind == e.kind, e.req, "kind", rsp_kind, e.kind);
                check(rsp_data == word_of(e.addr), e.req, "data", rsp_data, word_of(e.addr));
                check(cyc - accept_cyc + 1 == e.lat, e.req, "latency",
                      cyc - accept_cyc + 1, e.lat);
                check(!req_ready, "R8", "ready during response", req_ready, 0);
            end
        end
    end

    // next-level memory model
    initial forever begin
        @(posedge clk); #1;
        if (rst) begin
            mem_rsp_valid = 0; wait_cnt = 0;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid = 0;
        end else if (mem_req_valid) begin
            wait_cnt++;
            if (wait_cnt >= mem_lat) begin
                check(mem_req_addr == exp_mem_addr, "R5", "refill address",
                      mem_req_addr, exp_mem_addr);
                mem_rsp_data  = word_of(mem_req_addr);
                mem_rsp_valid = 1;
                wait_cnt      = 0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(0, "R8", "watchdog expired", cyc, WATCHDOG);
        finish_run();
    end

    localparam logic [ADDR_W-1:0] A = 12'h010; // index 0
    localparam logic [ADDR_W-1:0] B = 12'h110; // index 0, other tag
    localparam logic [ADDR_W-1:0] C = 12'h014; // index 4, differs from A in index top bit
    localparam logic [ADDR_W-1:0] D = 12'h023; // index 3

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid === 1'b0, "R1", "no response after reset", rsp_valid, 0);
        check(mem_req_valid === 1'b0, "R1", "no refill after reset", mem_req_valid, 0);

        for (int pass = 0; pass < 2; pass++) begin
            mem_lat = (pass == 0) ? 1 : 4;
            if (pass == 1) begin
                @(negedge clk) rst = 1;
                @(negedge clk) rst = 0;
            end
            send(A, 2'b11, "R1");  // cold miss
            send(A, 2'b01, "R2");  // home hit
            send(B, 2'b11, "R5");  // collide: B home, A partner
            send(A, 2'b10, "R3");  // slow hit, swap
            send(A, 2'b01, "R4");  // now fast
            send(B, 2'b10, "R4");  // displaced line slow, swap back
            send(C, 2'b11, "R7");  // no alias with A; C home, A partner, B dropped
            send(A, 2'b01, "R6");  // old home (A) moved to partner slot 0
            send(C, 2'b01, "R7");
            send(B, 2'b11, "R6");  // B was dropped
            send(C, 2'b11, "R6");  // C dropped by previous refill
            send(A, 2'b01, "R6");
            send(D, 2'b11, "R5");
            send(D, 2'b01, "R2");
        end
        check(q.size() == 0, "R8", "outstanding expectations", q.size(), 0);
        finish_run();
    end
endmodule